// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Controller

This block gathers up to 64 interrupt sources, arranged as banks of 32, and merges them into one request line for a processor. A fixed mask for each bank, set by a parameter, divides the inputs into two kinds. Edge sources latch a rising transition into a sticky event bit. Level sources never latch anything. Their present state is visible only through a live level view. An enable bit for each source gates whether it can raise the request. Software clears a latched edge by writing ones to the acknowledge word.

Software reaches the controller through a simple 32-bit word port with byte addresses. Each bank shows four words: event, enable, acknowledge and level. The banks are stacked so that the highest-numbered bank sits at the lowest address. The request of a second, downstream controller can be wired to any input and is then handled like any other source. There is no priority logic. Software scans the bits it reads back.

Top module: `mixed_irq_ctrl`

## Requirements
- R1: After reset, every enable bit and every event bit is 0 and `irq_out` is low.
- R2: A 0-to-1 change on an edge source sets that source's event bit at the next clock edge, whether or not the source is enabled.
- R3: Writing the acknowledge word of a bank clears each event bit whose write-data bit is 1. Event bits whose write-data bit is 0 are kept.
- R4: If a rising edge and an acknowledge write of the same bit fall in the same cycle, the edge wins and the event bit stays 1.
- R5: Level sources never set an event bit. The level word returns the sampled state of all 32 inputs of the bank, both edge and level sources.
- R6: Reading the enable word returns the value last written to it. The word changes only when it is written.
- R7: `irq_out` is high exactly when some bank has a bit set in (event OR (level-sampled AND level mask)) AND enable. It follows the registers in the same cycle.
- R8: Setting an enable bit while its edge source is already high, with no event latched, neither sets the event bit nor raises `irq_out`.
- R9: Bank b sits at byte base (NUM_BANKS-1-b)*0x10. Within a bank the word offsets are 0x0 event, 0x4 enable, 0x8 acknowledge and 0xC level. The acknowledge word reads as 0. An address with bits [1:0] not 00 hits nothing and reads 0. Read data appears one clock after the read strobe and holds until the next read.
- R10: The level mask is a parameter for each bank. By default bank 0 uses 0x3FF00000 (bits 20 to 29) and bank 1 uses 0x1FF00000 (bits 20 to 28), so bit 29 is level in bank 0 and edge in bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | 64 | Interrupt inputs; bit 32*b+i is input i of bank b |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data; bit 0 is the least significant byte lane |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A change on an input that the clock samples at edge N shows up in the event bits, in the level word and on `irq_out` right after edge N. A write strobed at edge N takes effect right after that same edge. Read data is due one edge after the read strobe. The bench drives every stimulus on a falling edge and samples `irq_out` on the following falling edge. Every read pushes its expected word into a queue, and a monitor pops that word and compares it on the falling edge that follows the rising edge of the read.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    WSEL_EVENT  = 2'd0,
    WSEL_ENABLE = 2'd1,
    WSEL_ACK    = 2'd2,
    WSEL_LEVEL  = 2'd3
  } word_sel_e;

  localparam int unsigned BANK_STRIDE_LOG2 = 4;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ns = stage_q[1];
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output word_sel_e            wsel,
  output logic [NUM_BANKS-1:0] en_we,
  output logic [NUM_BANKS-1:0] ack_we
);
  localparam int BSEL_W = ADDR_W - BANK_STRIDE_LOG2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);
  assign wsel    = word_sel_e'(addr[3:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    localparam int SLOT = NUM_BANKS - 1 - b;
    assign bank_hit[b] = aligned && (addr[ADDR_W-1:BANK_STRIDE_LOG2] == BSEL_W'(SLOT));
    assign en_we[b]    = wr && bank_hit[b] && (wsel == WSEL_ENABLE);
    assign ack_we[b]   = wr && bank_hit[b] && (wsel == WSEL_ACK);
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int               BANK_W   = 32,
  parameter logic [BANK_W-1:0] LVL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic [BANK_W-1:0] src,
  input  logic              en_we,
  input  logic              ack_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] event_q,
  output logic [BANK_W-1:0] enable_q,
  output logic [BANK_W-1:0] level_q,
  output logic              req
);
  logic [BANK_W-1:0] rise;
  logic [BANK_W-1:0] ack_clr;
  logic [BANK_W-1:0] event_d;
  logic [BANK_W-1:0] enable_d;
  logic              event_ce;

  always_comb begin
    rise     = src & ~level_q & ~LVL_MASK;
    ack_clr  = ack_we ? wdata : '0;
    event_d  = (event_q & ~ack_clr) | rise;
    event_ce = ack_we || (|rise);
    enable_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      event_q  <= '0;
      enable_q <= '0;
      level_q  <= '0;
    end else begin
      if (event_ce) event_q  <= event_d;
      if (en_we)    enable_q <= enable_d;
      level_q <= src;
    end
  end

  assign req = |((event_q | (level_q & LVL_MASK)) & enable_q);

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_ns)
    (|rise) |=> ((event_q & $past(rise)) == $past(rise))); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    ack_we |=> ((event_q & $past(wdata & ~rise)) == '0)); // R3
  AST_ACK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_ns)
    ack_we |=> ((event_q & $past(event_q & ~wdata)) == $past(event_q & ~wdata))); // R3
  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_ns)
    (ack_we && |(rise & wdata)) |=> ((event_q & $past(rise & wdata)) == $past(rise & wdata))); // R4
  AST_NO_SPURIOUS_EVENT: assert property (@(posedge clk) disable iff (!rst_ns)
    ((event_q & ~$past(event_q) & ~$past(rise)) == '0)); // R8
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_ns)
    en_we |=> (enable_q == $past(wdata))); // R6
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !en_we |=> $stable(enable_q)); // R6
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASKS = {32'h1FF0_0000, 32'h3FF0_0000},
  localparam int NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int ADDR_W   = $clog2(NUM_BANKS > 1 ? NUM_BANKS : 2) + BANK_STRIDE_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [BANK_W-1:0]  reg_wdata,
  output logic [BANK_W-1:0]  reg_rdata,
  output logic               irq_out
);
  logic                              rst_ns;
  logic [NUM_BANKS-1:0]              bank_hit;
  logic [NUM_BANKS-1:0]              en_we;
  logic [NUM_BANKS-1:0]              ack_we;
  word_sel_e                         wsel;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  ev_w;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  en_w;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  lv_w;
  logic [NUM_BANKS-1:0]              bank_req;
  logic [BANK_W-1:0]                 rd_mux;
  logic [BANK_W-1:0]                 rdata_q;

  irq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  irq_reg_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .addr     (reg_addr),
    .wr       (reg_wr),
    .bank_hit (bank_hit),
    .wsel     (wsel),
    .en_we    (en_we),
    .ack_we   (ack_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_src_bank #(
      .BANK_W   (BANK_W),
      .LVL_MASK (LEVEL_MASKS[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk      (clk),
      .rst_ns   (rst_ns),
      .src      (src_in[b*BANK_W +: BANK_W]),
      .en_we    (en_we[b]),
      .ack_we   (ack_we[b]),
      .wdata    (reg_wdata),
      .event_q  (ev_w[b]),
      .enable_q (en_w[b]),
      .level_q  (lv_w[b]),
      .req      (bank_req[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        unique case (wsel)
          WSEL_EVENT:  rd_mux = ev_w[b];
          WSEL_ENABLE: rd_mux = en_w[b];
          WSEL_LEVEL:  rd_mux = lv_w[b];
          default:     rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = |bank_req;

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_rd && (wsel == WSEL_ACK)) |=> (reg_rdata == '0)); // R9
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_rd && (bank_hit == '0)) |=> (reg_rdata == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !reg_rd |=> $stable(reg_rdata)); // R9
  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_ns)
    (en_w == '0) |-> !irq_out); // R7
endmodule

// File: tb/tb_mixed_irq_ctrl.sv
module tb_mixed_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [4:0] EV0 = 5'h10, EN0 = 5'h14, AK0 = 5'h18, LV0 = 5'h1C;
  localparam logic [4:0] EV1 = 5'h00, EN1 = 5'h04, AK1 = 5'h08, LV1 = 5'h0C;

  always #5 clk = ~clk;

  mixed_irq_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    rd(EN0, 32'h0, "R1 enable0 reset");
    rd(EV0, 32'h0, "R1 event0 reset");
    rd(EN1, 32'h0, "R1 enable1 reset");

    src_in[3] = 1'b1; tick();
    rd(EV0, 32'h0000_0008, "R2 edge latched while disabled");
    chk("R7 irq low when disabled", {31'd0, irq_out}, 32'd0);

    wr(EN0, 32'h0000_0008);
    chk("R7 irq on enabled event", {31'd0, irq_out}, 32'd1);
    rd(EN0, 32'h0000_0008, "R6 enable readback");

    wr(AK0, 32'h0);
    rd(EV0, 32'h0000_0008, "R3 zero ack keeps event");
    wr(AK0, 32'h0000_0008);
    chk("R3 irq drops after ack", {31'd0, irq_out}, 32'd0);
    rd(EV0, 32'h0, "R3 ack clears event");
    rd(AK0, 32'h0, "R9 ack reads zero");

    src_in[5] = 1'b1; tick();
    wr(AK0, 32'h0000_0020);
    wr(EN0, 32'h0000_0028);
    chk("R8 enable of high input no irq", {31'd0, irq_out}, 32'd0);
    rd(EV0, 32'h0, "R8 enable of high input no event");

    src_in[20] = 1'b1; tick();
    rd(EV0, 32'h0, "R5 level source no event");
    rd(LV0, 32'h0010_0028, "R5 level word live");
    chk("R7 level disabled no irq", {31'd0, irq_out}, 32'd0);
    wr(EN0, 32'h0010_0028);
    chk("R7 level enabled irq", {31'd0, irq_out}, 32'd1);
    src_in[20] = 1'b0; tick();
    chk("R7 level drop clears irq", {31'd0, irq_out}, 32'd0);

    src_in[29] = 1'b1; src_in[61] = 1'b1; tick();
    rd(EV0, 32'h0, "R10 bank0 bit29 is level");
    rd(EV1, 32'h2000_0000, "R10 bank1 bit29 is edge");
    rd(LV1, 32'h2000_0000, "R5 bank1 level word");

    src_in[32] = 1'b1;
    wr(AK1, 32'h0000_0001);
    rd(EV1, 32'h2000_0001, "R4 edge beats ack");

    wr(EN1, 32'h0000_0001);
    chk("R7 bank1 request", {31'd0, irq_out}, 32'd1);
    wr(AK1, 32'h0000_0001);
    chk("R3 bank1 ack drops irq", {31'd0, irq_out}, 32'd0);
    rd(EV1, 32'h2000_0000, "R3 bank1 ack leaves other bit");
    rd(EN1, 32'h0000_0001, "R9 bank1 enable at 0x04");
    rd(5'h05, 32'h0, "R9 misaligned reads zero");

    repeat (2) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule